// File: doc/BRIEF.md
# Scatter-Gather List Walker

This block feeds a downstream hash datapath from a list of buffer descriptors kept in memory. Software lays out the list and the buffers, then pulses a start input with the list base address and the expected total message length. The walker reads each descriptor through a single-word memory read port and fetches the buffer it names. It hands the bytes on as one gap-free byte stream with valid/ready flow control, so a message split over several buffers hashes exactly like the same bytes held in one place.

Every descriptor takes two 32-bit little-endian words. The top bit of the length word marks the final entry. The walker keeps a running byte count against the programmed total. Once it has finished, it pulses done for one cycle and sets an error flag in that same cycle if the list and the programmed total disagree.

Top module: `sg_walker`

## Requirements
- R1: After reset, out_valid_o, done_o, err_o and mem_req_o are all low.
- R2: A descriptor occupies 8 bytes starting at a 4-aligned address. The length word sits at offset 0 and the buffer address word at offset 4. The first descriptor is at the list base, and each later one is 8 bytes after the previous. Each mem_req_o pulse is a one-cycle request for the 32-bit word at a 4-aligned address, answered by mem_rvalid_i one or more cycles later. At most one request is outstanding.
- R3: Buffer bytes leave in list order, and in address order within a buffer, with none dropped or repeated. The byte at address A is bits 8*(A mod 4)+7 down to 8*(A mod 4) of the word read at A rounded down to a multiple of 4.
- R4: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o holds its value.
- R5: A descriptor whose byte count is zero and whose final flag is clear emits no bytes, and the walk moves on to the next entry.
- R6: Bit 31 of the length word is the final flag and bits 30:0 are the byte count. The cycle after the final entry's last byte is accepted, done_o is high for exactly one cycle, with err_o low when the total streamed equals total_len_i.
- R7: If the final entry ends with fewer bytes streamed than total_len_i, the done pulse carries err_o high.
- R8: If a non-final entry brings the streamed count up to total_len_i, the walk stops after that entry and pulses done_o with err_o high.
- R9: If an entry's byte count exceeds the bytes still owed to total_len_i, none of its bytes are streamed and done_o pulses with err_o high.
- R10: A start pulse that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| list_base_i | input | ADDR_W | Address of the first descriptor |
| total_len_i | input | LEN_W | Expected message length in bytes |
| mem_req_o | output | 1 | One-cycle word read request |
| mem_addr_o | output | ADDR_W | 4-aligned word address of the request |
| mem_rvalid_i | input | 1 | Read data strobe |
| mem_rdata_i | input | 32 | Read data word, little-endian byte lanes |
| out_valid_o | output | 1 | Stream byte valid |
| out_data_o | output | 8 | Stream byte |
| out_ready_i | input | 1 | Downstream accepts the byte |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | List and total disagree (valid with done_o) |

## Verification
The assertions assume that the list base is 4-aligned. They also assume that the memory raises mem_rvalid_i only for a request that is outstanding, never more than once per request. The bench's memory model keeps one pending request, answers it after a random delay of one to three cycles, and stays silent otherwise. Every list it builds starts at a multiple of 64. Buffer addresses are left unaligned on purpose, so that all four byte lanes are exercised.

// File: rtl/sg_walker_pkg.sv
package sg_walker_pkg;

    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / 8;
    localparam int LANE_SEL_W = $clog2(LANES);
    localparam int DESC_BYTES = 8;
    localparam int ADR_OFFSET = 4;
    localparam int FINAL_BIT  = 31;
    localparam int DLEN_W     = FINAL_BIT;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH_LEN,
        S_WAIT_LEN,
        S_FETCH_ADR,
        S_WAIT_ADR,
        S_RD_BYTE,
        S_WAIT_BYTE,
        S_EMIT,
        S_DONE
    } walk_state_e;

endpackage

// File: rtl/sg_desc_decode.sv
module sg_desc_decode
    import sg_walker_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic [WORD_W-1:0] len_word_i,
    input  logic [LEN_W-1:0]  remaining_i,
    output logic              final_o,
    output logic [DLEN_W-1:0] count_o,
    output logic              zero_o,
    output logic              too_long_o
);

    localparam int CMP_W = (LEN_W > DLEN_W) ? LEN_W : DLEN_W;

    always_comb begin
        final_o    = len_word_i[FINAL_BIT];
        count_o    = len_word_i[DLEN_W-1:0];
        zero_o     = (count_o == '0);
        too_long_o = CMP_W'(count_o) > CMP_W'(remaining_i);
    end

endmodule

// File: rtl/sg_byte_lane.sv
module sg_byte_lane
    import sg_walker_pkg::*;
(
    input  logic [WORD_W-1:0]     word_i,
    input  logic [LANE_SEL_W-1:0] sel_i,
    output logic [7:0]            byte_o
);

    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word_i[8*g +: 8];
    end

    assign byte_o = lanes[sel_i];

endmodule

// File: rtl/sg_walker.sv
module sg_walker
    import sg_walker_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] list_base_i,
    input  logic [LEN_W-1:0]  total_len_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              out_valid_o,
    output logic [7:0]        out_data_o,
    input  logic              out_ready_i,
    output logic              done_o,
    output logic              err_o
);

    localparam logic [ADDR_W-1:0] STEP_DESC = ADDR_W'(DESC_BYTES);
    localparam logic [ADDR_W-1:0] STEP_ADR  = ADDR_W'(ADR_OFFSET);

    typedef struct packed {
        walk_state_e       st;
        logic [ADDR_W-1:0] desc_ptr;
        logic [ADDR_W-1:0] buf_ptr;
        logic [DLEN_W-1:0] left;
        logic [LEN_W-1:0]  count;
        logic [LEN_W-1:0]  total;
        logic              fin;
        logic              zero;
        logic              too_long;
        logic [7:0]        data;
        logic              err;
    } walk_t;

    walk_t q, d;

    logic [LEN_W-1:0]  remaining;
    logic              dec_final;
    logic [DLEN_W-1:0] dec_count;
    logic              dec_zero;
    logic              dec_too_long;
    logic [7:0]        lane_byte;
    logic [LEN_W-1:0]  cnt_next;

    assign remaining = q.total - q.count;
    assign cnt_next  = q.count + LEN_W'(1);

    sg_desc_decode #(.LEN_W(LEN_W)) u_dec (
        .len_word_i  (mem_rdata_i),
        .remaining_i (remaining),
        .final_o     (dec_final),
        .count_o     (dec_count),
        .zero_o      (dec_zero),
        .too_long_o  (dec_too_long)
    );

    sg_byte_lane u_lane (
        .word_i (mem_rdata_i),
        .sel_i  (q.buf_ptr[LANE_SEL_W-1:0]),
        .byte_o (lane_byte)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.st       = S_FETCH_LEN;
                    d.desc_ptr = list_base_i;
                    d.total    = total_len_i;
                    d.count    = '0;
                    d.err      = 1'b0;
                end
            end
            S_FETCH_LEN: d.st = S_WAIT_LEN;
            S_WAIT_LEN: begin
                if (mem_rvalid_i) begin
                    d.left     = dec_count;
                    d.fin      = dec_final;
                    d.zero     = dec_zero;
                    d.too_long = dec_too_long;
                    d.st       = S_FETCH_ADR;
                end
            end
            S_FETCH_ADR: d.st = S_WAIT_ADR;
            S_WAIT_ADR: begin
                if (mem_rvalid_i) begin
                    if (q.too_long) begin
                        d.st  = S_DONE;
                        d.err = 1'b1;
                    end else if (q.zero) begin
                        if (q.fin) begin
                            d.st  = S_DONE;
                            d.err = (q.count != q.total);
                        end else if (q.count == q.total) begin
                            d.st  = S_DONE;
                            d.err = 1'b1;
                        end else begin
                            d.desc_ptr = q.desc_ptr + STEP_DESC;
                            d.st       = S_FETCH_LEN;
                        end
                    end else begin
                        d.buf_ptr = mem_rdata_i[ADDR_W-1:0];
                        d.st      = S_RD_BYTE;
                    end
                end
            end
            S_RD_BYTE: d.st = S_WAIT_BYTE;
            S_WAIT_BYTE: begin
                if (mem_rvalid_i) begin
                    d.data = lane_byte;
                    d.st   = S_EMIT;
                end
            end
            S_EMIT: begin
                if (out_ready_i) begin
                    d.count   = cnt_next;
                    d.left    = q.left - DLEN_W'(1);
                    d.buf_ptr = q.buf_ptr + ADDR_W'(1);
                    if (q.left == DLEN_W'(1)) begin
                        if (q.fin) begin
                            d.st  = S_DONE;
                            d.err = (cnt_next != q.total);
                        end else if (cnt_next == q.total) begin
                            d.st  = S_DONE;
                            d.err = 1'b1;
                        end else begin
                            d.desc_ptr = q.desc_ptr + STEP_DESC;
                            d.st       = S_FETCH_LEN;
                        end
                    end else begin
                        d.st = S_RD_BYTE;
                    end
                end
            end
            S_DONE: d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_req_o  = 1'b0;
        mem_addr_o = '0;
        unique case (q.st)
            S_FETCH_LEN: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.desc_ptr;
            end
            S_FETCH_ADR: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.desc_ptr + STEP_ADR;
            end
            S_RD_BYTE: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {q.buf_ptr[ADDR_W-1:LANE_SEL_W], LANE_SEL_W'(0)};
            end
            default: ;
        endcase
    end

    assign out_valid_o = (q.st == S_EMIT);
    assign out_data_o  = q.data;
    assign done_o      = (q.st == S_DONE);
    assign err_o       = (q.st == S_DONE) && q.err;

endmodule

// File: rtl/sg_walker_checker.sv
module sg_walker_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              out_valid_o,
    input logic [7:0]        out_data_o,
    input logic              out_ready_i,
    input logic              done_o,
    input logic              err_o
);

    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    p_req_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

    p_no_read_while_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !mem_req_o);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!out_valid_o && !mem_req_o));

    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

endmodule

bind sg_walker sg_walker_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_ready_i (out_ready_i),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/sg_walker_bench.sv
`timescale 1ns/1ps
module sg_walker_bench;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 24;
    localparam int MAXD   = 8;
    localparam int MAXB   = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] list_base_i = '0;
    logic [LEN_W-1:0]  total_len_i = '0;
    logic              mem_req_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic              mem_rvalid_i;
    logic [31:0]       mem_rdata_i;
    logic              out_valid_o;
    logic [7:0]        out_data_o;
    logic              out_ready_i = 1'b1;
    logic              done_o;
    logic              err_o;

    always #2 clk = ~clk;

    sg_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_sg_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .list_base_i(list_base_i), .total_len_i(total_len_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o),
        .out_ready_i(out_ready_i), .done_o(done_o), .err_o(err_o)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem [4096];

    function automatic logic [31:0] word_at(input logic [31:0] a);
        logic [11:0] b;
        b = {a[11:2], 2'b00};
        return {mem[b + 12'd3], mem[b + 12'd2], mem[b + 12'd1], mem[b]};
    endfunction

    // memory model: one pending request, random 1..3 cycle latency
    int          pend_cnt = 0;
    logic [31:0] pend_addr = '0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rvalid_i <= 1'b0;
            mem_rdata_i  <= '0;
            pend_cnt     <= 0;
        end else begin
            mem_rvalid_i <= 1'b0;
            if (pend_cnt > 0) begin
                pend_cnt <= pend_cnt - 1;
                if (pend_cnt == 1) begin
                    mem_rvalid_i <= 1'b1;
                    mem_rdata_i  <= word_at(pend_addr);
                end
            end else if (mem_req_o) begin
                pend_addr <= mem_addr_o;
                pend_cnt  <= 1 + int'($urandom % 3);
            end
        end
    end

    // ready driver
    int rdy_mode = 0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready_i = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor
    logic [7:0] got [MAXB];
    int  got_n    = 0;
    int  done_cnt = 0;
    bit  got_err  = 0;
    bit  hold_pend = 0;
    logic [7:0] hold_data = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend) begin
                // R4: held byte must stay presented
                check(out_valid_o && (out_data_o == hold_data), "R4", "held byte",
                      int'(out_data_o), int'(hold_data));
            end
            hold_pend = out_valid_o && !out_ready_i;
            hold_data = out_data_o;
            if (out_valid_o && out_ready_i && got_n < MAXB) begin
                got[got_n] = out_data_o;
                got_n = got_n + 1;
            end
            if (done_o) begin
                done_cnt = done_cnt + 1;
                got_err  = err_o;
            end
        end
    end

    // scenario description
    int         d_n;
    int         d_len  [MAXD];
    bit         d_fin  [MAXD];
    int         d_addr [MAXD];
    logic [7:0] exp_b  [MAXB];
    int         exp_n;
    bit         exp_err;

    task automatic put_word(input int a, input logic [31:0] w);
        for (int k = 0; k < 4; k++) mem[12'(a + k)] = w[8*k +: 8];
    endtask

    task automatic build_list(input int base);
        for (int i = 0; i < d_n; i++) begin
            put_word(base + 8*i, {d_fin[i], 31'(d_len[i])});
            put_word(base + 8*i + 4, 32'(d_addr[i]));
            for (int k = 0; k < d_len[i]; k++) mem[12'(d_addr[i] + k)] = 8'($urandom);
        end
    endtask

    task automatic model(input int total);
        int cnt;
        bit stop;
        cnt = 0; exp_n = 0; exp_err = 0; stop = 0;
        for (int i = 0; i < d_n && !stop; i++) begin
            if (d_len[i] > total - cnt) begin
                exp_err = 1; stop = 1;
            end else begin
                for (int k = 0; k < d_len[i]; k++) begin
                    exp_b[exp_n] = mem[12'(d_addr[i] + k)];
                    exp_n = exp_n + 1;
                end
                cnt = cnt + d_len[i];
                if (d_fin[i]) begin
                    exp_err = (cnt != total); stop = 1;
                end else if (cnt == total) begin
                    exp_err = 1; stop = 1;
                end
            end
        end
    endtask

    task automatic pulse_start(input int base, input int total);
        @(posedge clk); #1;
        start_i     = 1'b1;
        list_base_i = 32'(base);
        total_len_i = 24'(total);
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic run_case(input string req, input int base, input int total,
                            input bit poke);
        int wait_cyc;
        int first_bad;
        build_list(base);
        model(total);
        got_n = 0; done_cnt = 0; got_err = 0;
        pulse_start(base, total);
        if (poke) begin
            repeat (6) @(posedge clk);
            // competing list at 0x180: one 4-byte final entry at 0x900
            put_word(32'h180, {1'b1, 31'd4});
            put_word(32'h184, 32'h900);
            pulse_start(32'h180, 4);
        end
        wait_cyc = 0;
        while (done_cnt == 0 && wait_cyc < 4000) begin
            @(negedge clk);
            wait_cyc++;
        end
        repeat (30) @(negedge clk);
        check(got_n == exp_n, req, "byte count", got_n, exp_n);
        first_bad = -1;
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (first_bad < 0 && got[i] != exp_b[i]) first_bad = i;
        check(first_bad < 0, req, "first mismatching byte index", first_bad, -1);
        check(got_err == exp_err, req, "err flag", int'(got_err), int'(exp_err));
        check(done_cnt == 1, req, "done pulses", done_cnt, 1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cursor;
        int total;
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!out_valid_o && !done_o && !err_o && !mem_req_o, "R1", "idle outputs in reset",
              int'({out_valid_o, done_o, err_o, mem_req_o}), 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid_o && !done_o && !err_o && !mem_req_o, "R1", "idle outputs after reset",
              int'({out_valid_o, done_o, err_o, mem_req_o}), 0);

        // R2 R3 R6: three pieces 6+3+3 making 12
        d_n = 3;
        d_len[0] = 6; d_fin[0] = 0; d_addr[0] = 'h400;
        d_len[1] = 3; d_fin[1] = 0; d_addr[1] = 'h501;
        d_len[2] = 3; d_fin[2] = 1; d_addr[2] = 'h603;
        run_case("R2/R3 split list", 'h100, 12, 0);

        // R6: single final entry, unaligned buffer
        d_n = 1;
        d_len[0] = 7; d_fin[0] = 1; d_addr[0] = 'h412;
        run_case("R6 single entry", 'h140, 7, 0);

        // R5: zero-length non-final entries skipped
        d_n = 4;
        d_len[0] = 4; d_fin[0] = 0; d_addr[0] = 'h420;
        d_len[1] = 0; d_fin[1] = 0; d_addr[1] = 'h700;
        d_len[2] = 0; d_fin[2] = 0; d_addr[2] = 'h710;
        d_len[3] = 5; d_fin[3] = 1; d_addr[3] = 'h431;
        run_case("R5 zero-length skip", 'h100, 9, 0);

        // R4: backpressure on the stream
        rdy_mode = 1;
        d_n = 2;
        d_len[0] = 9; d_fin[0] = 0; d_addr[0] = 'h441;
        d_len[1] = 8; d_fin[1] = 1; d_addr[1] = 'h462;
        run_case("R4 backpressure", 'h1c0, 17, 0);

        // R7: final flag too early
        d_n = 2;
        d_len[0] = 6; d_fin[0] = 0; d_addr[0] = 'h400;
        d_len[1] = 3; d_fin[1] = 1; d_addr[1] = 'h480;
        run_case("R7 early final", 'h100, 12, 0);

        // R8: total reached by non-final entry
        d_n = 3;
        d_len[0] = 6; d_fin[0] = 0; d_addr[0] = 'h400;
        d_len[1] = 6; d_fin[1] = 0; d_addr[1] = 'h480;
        d_len[2] = 3; d_fin[2] = 1; d_addr[2] = 'h4c0;
        run_case("R8 total reached early", 'h100, 12, 0);

        // R9: entry longer than what remains
        d_n = 2;
        d_len[0] = 6;  d_fin[0] = 0; d_addr[0] = 'h400;
        d_len[1] = 10; d_fin[1] = 1; d_addr[1] = 'h480;
        run_case("R9 oversize entry", 'h100, 12, 0);

        // R10: start while busy is ignored
        rdy_mode = 0;
        d_n = 2;
        d_len[0] = 5; d_fin[0] = 0; d_addr[0] = 'h403;
        d_len[1] = 5; d_fin[1] = 1; d_addr[1] = 'h455;
        run_case("R10 start while busy", 'h100, 10, 1);

        // random lists, R3 R6 R7 R8 R9 mixed
        for (int r = 0; r < 24; r++) begin
            rdy_mode = r % 2;
            d_n = 1 + int'($urandom % 5);
            cursor = 'h400 + int'($urandom % 4);
            total = 0;
            for (int i = 0; i < d_n; i++) begin
                d_len[i]  = int'($urandom % 10);
                d_fin[i]  = (i == d_n - 1);
                d_addr[i] = cursor;
                cursor    = cursor + d_len[i] + int'($urandom % 4);
                total     = total + d_len[i];
            end
            if (($urandom % 4) == 0) total = total + 1;
            else if (($urandom % 4) == 0 && total > 0) total = total - 1;
            run_case("R3/R6 random list", 'h100 + 64 * int'($urandom % 4), total, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule